// File: doc/BRIEF.md
# Dual-Input Edge Set/Clear Flag

This block keeps a single status flag driven by two independent clock-like signals. A rising transition on the first monitored input raises the flag, and a falling transition on the second monitored input lowers it. The two monitored signals are not related to each other or to the block's own clock. Each may run anywhere between 5 and 50 MHz.

Both monitored signals are oversampled by one system clock that runs several times faster than either of them. Each signal passes through its own synchronizer and then its own edge detector. The two resulting one-cycle events meet in one register, so the flag has exactly one driver. If both events land in the same sampling cycle, the set wins. The synchronizers add a fixed latency of three sampling cycles from a monitored edge to the flag.

Top module: `edge_flag_monitor`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, the flag and every synchronizer and history flop are cleared to 0 (synchronous, active-low). After reset the flag reads 0.
- R2: A 0-to-1 transition on `mon_set` sets `flag` to 1. The flag changes at the third rising `clk` edge after the transition and not before.
- R3: A 1-to-0 transition on `mon_clr` clears `flag` to 0, with the same three-edge latency.
- R4: A falling transition on `mon_set` and a rising transition on `mon_clr` leave `flag` unchanged.
- R5: When a set event and a clear event are detected in the same sampling cycle, `flag` becomes 1.
- R6: The synchronizers are cleared by reset. If `mon_set` is held at 1 through reset release, this counts as a rising edge, and `flag` goes to 1 three cycles after release.
- R7: In any sampling cycle without a detected set or clear event, `flag` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, several times faster than either monitored input |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_set | input | 1 | Asynchronous monitored input; its rising edges set the flag |
| mon_clr | input | 1 | Asynchronous monitored input; its falling edges clear the flag |
| flag | output | 1 | The set/clear flag |

## Verification
The properties assume each monitored level is stable for at least two sampling periods, so that every edge appears as one clean old/new pair in the synchronizer. They predict the flag from the monitored inputs delayed by three and four cycles. For that reason they only arm after the synchronizer history has refilled following a reset. The bench drives the monitored inputs away from the sampling edge and holds each level for at least four sampling cycles. This keeps the stimulus inside that assumption while still producing simultaneous set and clear edges.

// File: rtl/edge_flag_pkg.sv
// Shared types for the dual-input edge flag.
// Assumes: nothing beyond being compiled before its users.
package edge_flag_pkg;
    // Which transition an edge detector reports.
    typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;
    // Which event wins when set and clear coincide.
    typedef enum logic {WIN_SET = 1'b0, WIN_CLEAR = 1'b1} win_e;
endpackage

// File: rtl/level_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; input may change at any time relative to clk.
module level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[TOP-1:0], async_in};
    end

    assign sync_out = chain_q[TOP];
endmodule

// File: rtl/edge_tap.sv
// Detects one kind of transition on a synchronized level, giving a
// one-cycle event. Assumes: input is already in the clk domain.
module edge_tap #(
    parameter edge_flag_pkg::edge_kind_e KIND = edge_flag_pkg::EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic evt
);
    logic prev_q;

    // Remember last cycle's level (the "old" sample).
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    generate
        if (KIND == edge_flag_pkg::EDGE_RISE) begin : g_rise
            assign evt = level & ~prev_q;
        end else begin : g_fall
            assign evt = ~level & prev_q;
        end
    endgenerate
endmodule

// File: rtl/flag_cell.sv
// Single set/clear register, the only driver of the flag.
// Assumes: set and clear are one-cycle events in the clk domain.
module flag_cell #(
    parameter edge_flag_pkg::win_e WINNER = edge_flag_pkg::WIN_SET
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic q
);
    logic nxt;

    generate
        if (WINNER == edge_flag_pkg::WIN_SET) begin : g_set_first
            // Next value with set taking priority.
            always_comb begin
                if (set_evt)      nxt = 1'b1;
                else if (clr_evt) nxt = 1'b0;
                else              nxt = q;
            end
        end else begin : g_clr_first
            // Next value with clear taking priority.
            always_comb begin
                if (clr_evt)      nxt = 1'b0;
                else if (set_evt) nxt = 1'b1;
                else              nxt = q;
            end
        end
    endgenerate

    // Hold the flag state.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
    end
endmodule

// File: rtl/edge_flag_monitor.sv
// Top: flag raised by rising edges of mon_set and lowered by falling
// edges of mon_clr, both oversampled by clk. Assumes clk is several times
// faster than either monitored input and each level lasts >= 2 clk periods.
module edge_flag_monitor #(
    parameter int                  SYNC_STAGES = 2,
    parameter edge_flag_pkg::win_e WINNER      = edge_flag_pkg::WIN_SET
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_set,
    input  logic mon_clr,
    output logic flag
);
    logic set_lvl, clr_lvl, set_evt, clr_evt;

    level_sync #(.STAGES(SYNC_STAGES)) u_sync_set (
        .clk(clk), .rst_n(rst_n), .async_in(mon_set), .sync_out(set_lvl));
    level_sync #(.STAGES(SYNC_STAGES)) u_sync_clr (
        .clk(clk), .rst_n(rst_n), .async_in(mon_clr), .sync_out(clr_lvl));

    edge_tap #(.KIND(edge_flag_pkg::EDGE_RISE)) u_tap_set (
        .clk(clk), .rst_n(rst_n), .level(set_lvl), .evt(set_evt));
    edge_tap #(.KIND(edge_flag_pkg::EDGE_FALL)) u_tap_clr (
        .clk(clk), .rst_n(rst_n), .level(clr_lvl), .evt(clr_evt));

    flag_cell #(.WINNER(WINNER)) u_flag (
        .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_evt(clr_evt),
        .q(flag));
endmodule

// File: rtl/edge_flag_monitor_chk.sv
// Port-level properties for edge_flag_monitor (default 2-stage sync).
// Assumes: each monitored level holds >= 2 clk periods.
module edge_flag_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic mon_set,
    input logic mon_clr,
    input logic flag
);
    logic [2:0] since_rst;

    // Count cycles since reset release, saturating, to arm the history checks.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    wire armed = (since_rst >= 3'd5);

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd0) |-> !flag);

    // R2
    set_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(mon_set, 3) && !$past(mon_set, 4)) |-> flag);

    // R3
    clr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !($past(mon_set, 3) && !$past(mon_set, 4))
               && !$past(mon_clr, 3) && $past(mon_clr, 4)) |-> !flag);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !($past(mon_set, 3) && !$past(mon_set, 4))
               && !(!$past(mon_clr, 3) && $past(mon_clr, 4))) |-> $stable(flag));
endmodule

bind edge_flag_monitor edge_flag_monitor_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mon_set(mon_set), .mon_clr(mon_clr),
    .flag(flag));

// File: tb/edge_flag_monitor_tb_top.sv
module edge_flag_monitor_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_set = 1'b0;
    logic mon_clr = 1'b0;
    logic flag;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    edge_flag_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .mon_set(mon_set), .mon_clr(mon_clr),
        .flag(flag));

    // {mon_set, mon_clr, expected flag, requirement number}
    localparam int NVEC = 13;
    localparam logic [5:0] VECS [NVEC] = '{
        {1'b1, 1'b0, 1'b1, 3'd2}, {1'b1, 1'b1, 1'b1, 3'd4},
        {1'b1, 1'b0, 1'b0, 3'd3}, {1'b0, 1'b0, 1'b0, 3'd4},
        {1'b1, 1'b1, 1'b1, 3'd2}, {1'b0, 1'b0, 1'b0, 3'd3},
        {1'b1, 1'b1, 1'b1, 3'd2}, {1'b0, 1'b0, 1'b0, 3'd3},
        {1'b0, 1'b1, 1'b0, 3'd4}, {1'b1, 1'b0, 1'b1, 3'd5},
        {1'b0, 1'b0, 1'b1, 3'd4}, {1'b0, 1'b1, 1'b1, 3'd7},
        {1'b0, 1'b0, 1'b0, 3'd3}
    };

    function automatic string tag(input logic [2:0] n);
        case (n)
            3'd1: return "R1";
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            3'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: flag=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic prev;
        repeat (3) @(negedge clk);
        check("R1", flag, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", flag, 1'b0);
        prev = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            mon_set = VECS[i][5];
            mon_clr = VECS[i][4];
            repeat (2) @(negedge clk);
            check(tag(VECS[i][2:0]), flag, prev);   // not yet after two edges
            @(negedge clk);
            check(tag(VECS[i][2:0]), flag, VECS[i][3]);
            @(negedge clk);
            check("R7", flag, VECS[i][3]);
            prev = VECS[i][3];
        end

        // R1: reset in the middle of operation, with mon_set held high
        mon_set = 1'b1;
        repeat (4) @(negedge clk);
        check("R2", flag, 1'b1);
        rst_n = 1'b0;
        mon_clr = 1'b1;
        @(negedge clk);
        check("R1", flag, 1'b0);
        mon_clr = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", flag, 1'b0);

        // R6: mon_set still high at release counts as a rising edge
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R6", flag, 1'b0);
        @(negedge clk);
        check("R6", flag, 1'b1);

        // R5: set and clear together from a flag-low state
        mon_clr = 1'b1;
        mon_set = 1'b0;
        repeat (4) @(negedge clk);
        check("R4", flag, 1'b1);
        mon_clr = 1'b0;
        repeat (4) @(negedge clk);
        check("R3", flag, 1'b0);
        mon_clr = 1'b1;
        repeat (4) @(negedge clk);
        mon_set = 1'b1;
        mon_clr = 1'b0;
        repeat (3) @(negedge clk);
        check("R5", flag, 1'b1);
        repeat (4) @(negedge clk);
        check("R7", flag, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule